// File: doc/BRIEF.md
# Inbound Address Translation Window

This block holds a single inbound window that redirects part of the PCI memory space into local bus space. Software programs it through three registers: a size/attribute register, a base address register and a local address register. The size/attribute register carries the window enable and a size mask. The base address register selects which region of PCI space the window claims. The local address register gives the local address that region lands on.

A combinational path takes an incoming PCI address. It reports whether that address falls inside the window and, when it does, returns the translated local address. Address bits covered by the mask are taken from the local address register. Bits outside the mask, which are the offset within the window, pass through unchanged. The granule is one page of 2^PAGE_W bytes, which is 4 KB by default, and that page is the smallest window allowed.

The base register is write-protected while the window is off. The enable bit has no reset value, so software must program it before it relies on any match result. To retire the window safely, software sets enable, writes zero to the base and then clears enable.

Top module: `inb_xlate_win`

## Requirements
- R1: After a synchronous active-low reset, the base and local registers read as zero and the size mask field reads as zero. The enable bit is left undefined by reset.
- R2: Register select 0 is the size/attribute register. Bit 0 is the enable. Bits PAGE_W-1..1 always read zero. Bits 31..PAGE_W hold the size mask exactly as written.
- R3: Register select 1 is the base register. While enable is clear, writes to it leave the stored value unchanged and reads of it return zero.
- R4: The base register (select 1) and the local register (select 2) store only bits 31..PAGE_W. Their low PAGE_W bits always read as zero.
- R5: win_hit is 1 only when all three of these hold: enable is set, the stored base is nonzero, and (pci_addr & mask) equals (base & mask), where mask is {size mask, PAGE_W zero bits}.
- R6: When win_hit is 1, local_addr equals (local & mask) | (pci_addr & ~mask). When win_hit is 0, local_addr is zero.
- R7: Register select 3 reads as zero, and writes to it change no register.
- R8: After the shutdown sequence (set enable, write base 0, clear enable), no address hits. If the window is enabled again, the base still reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Write strobe for the selected register |
| reg_sel | input | 2 | Register select: 0 attr, 1 base, 2 local, 3 unused |
| reg_wdata | input | ADDR_W | Write data |
| reg_rdata | output | ADDR_W | Combinational read data of the selected register |
| pci_addr | input | ADDR_W | Incoming PCI memory address |
| win_hit | output | 1 | Address falls inside the enabled window |
| local_addr | output | ADDR_W | Translated local address, zero on a miss |

## Verification
The bench builds the block with its defaults: ADDR_W of 32 and PAGE_W of 12. This makes the 4 KB minimum window reachable, with mask FFFFF000h, as well as the 16 MB example mask FF000000h. It also means the reserved field is 11 bits wide, so a write of all ones shows that those bits read back as zero. Under these values the table walk covers the edges of the window, just inside and just outside. The directed tests then cover the 4 KB page edge, the protected base and the shutdown sequence. Other page widths are not built by the bench.

// File: rtl/inb_xlate_pkg.sv
// Shared definitions for the inbound translation window.
// Assumes a two-bit register select on the register port.
package inb_xlate_pkg;
    typedef enum logic [1:0] {
        SEL_ATTR  = 2'd0,
        SEL_BASE  = 2'd1,
        SEL_LOCAL = 2'd2,
        SEL_NONE  = 2'd3
    } win_sel_e;
endpackage

// File: rtl/inb_win_regs.sv
// Register file of the window: enable, size mask, base and local page.
// Assumes single-cycle writes; read data is combinational on reg_sel.
// The base is write-protected while enable is clear; enable has no reset.
module inb_win_regs
    import inb_xlate_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PAGE_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_we,
    input  logic [1:0]               reg_sel,
    input  logic [ADDR_W-1:0]        reg_wdata,
    output logic [ADDR_W-1:0]        reg_rdata,
    output logic                     en_q,
    output logic [ADDR_W-1:PAGE_W]   mask_q,
    output logic [ADDR_W-1:PAGE_W]   base_q,
    output logic [ADDR_W-1:PAGE_W]   loc_q
);
    localparam int HI_W = ADDR_W - PAGE_W;

    win_sel_e sel;
    logic     unused_wbits;

    assign sel          = win_sel_e'(reg_sel);
    assign unused_wbits = ^reg_wdata[PAGE_W-1:1];

    // Enable bit: written from bit 0, deliberately left without reset.
    always_ff @(posedge clk) begin
        if (reg_we && sel == SEL_ATTR)
            en_q <= reg_wdata[0];
    end

    // Size mask: upper field of the attribute register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (reg_we && sel == SEL_ATTR)
            mask_q <= reg_wdata[ADDR_W-1:PAGE_W];
    end

    // Base page: accepted only while the window is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            base_q <= '0;
        else if (reg_we && sel == SEL_BASE && en_q)
            base_q <= reg_wdata[ADDR_W-1:PAGE_W];
    end

    // Local page: always writable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            loc_q <= '0;
        else if (reg_we && sel == SEL_LOCAL)
            loc_q <= reg_wdata[ADDR_W-1:PAGE_W];
    end

    // Read multiplexer with reserved and protected fields forced to zero.
    always_comb begin
        unique case (sel)
            SEL_ATTR:  reg_rdata = {mask_q, {(PAGE_W-1){1'b0}}, en_q};
            SEL_BASE:  reg_rdata = en_q ? {base_q, {PAGE_W{1'b0}}} : '0;
            SEL_LOCAL: reg_rdata = {loc_q, {PAGE_W{1'b0}}};
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/inb_win_match.sv
// Combinational window decode: masked compare of the PCI address
// against the base page and page-wise replacement with the local page.
// Assumes the page offset bits are never part of the mask.
module inb_win_match #(
    parameter int ADDR_W = 32,
    parameter int PAGE_W = 12
) (
    input  logic                   en_q,
    input  logic [ADDR_W-1:PAGE_W] mask_q,
    input  logic [ADDR_W-1:PAGE_W] base_q,
    input  logic [ADDR_W-1:PAGE_W] loc_q,
    input  logic [ADDR_W-1:0]      pci_addr,
    output logic                   win_hit,
    output logic [ADDR_W-1:0]      local_addr
);
    logic [ADDR_W-1:PAGE_W] diff;
    logic [ADDR_W-1:PAGE_W] xl;

    // One compare/replace slice per page-number bit.
    for (genvar b = PAGE_W; b < ADDR_W; b++) begin : g_bit
        assign diff[b] = mask_q[b] & (pci_addr[b] ^ base_q[b]);
        assign xl[b]   = mask_q[b] ? loc_q[b] : pci_addr[b];
    end

    // Hit needs enable, a nonzero base and no masked mismatch.
    always_comb begin
        win_hit    = en_q && (|base_q) && !(|diff);
        local_addr = win_hit ? {xl, pci_addr[PAGE_W-1:0]} : '0;
    end
endmodule

// File: rtl/inb_xlate_win.sv
// Top of the inbound translation window: register file plus decode.
// Assumes software programs the enable before relying on win_hit.
module inb_xlate_win #(
    parameter int ADDR_W = 32,
    parameter int PAGE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic [ADDR_W-1:0] pci_addr,
    output logic              win_hit,
    output logic [ADDR_W-1:0] local_addr
);
    logic                   en_q;
    logic [ADDR_W-1:PAGE_W] mask_q;
    logic [ADDR_W-1:PAGE_W] base_q;
    logic [ADDR_W-1:PAGE_W] loc_q;

    inb_win_regs #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .en_q      (en_q),
        .mask_q    (mask_q),
        .base_q    (base_q),
        .loc_q     (loc_q)
    );

    inb_win_match #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_match (
        .en_q       (en_q),
        .mask_q     (mask_q),
        .base_q     (base_q),
        .loc_q      (loc_q),
        .pci_addr   (pci_addr),
        .win_hit    (win_hit),
        .local_addr (local_addr)
    );
endmodule

// File: rtl/inb_xlate_win_chk.sv
// Property checker for the translation window, bound into the top.
module inb_xlate_win_chk #(
    parameter int ADDR_W = 32,
    parameter int PAGE_W = 12
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   reg_we,
    input logic [1:0]             reg_sel,
    input logic [ADDR_W-1:0]      reg_rdata,
    input logic                   win_hit,
    input logic [ADDR_W-1:0]      local_addr,
    input logic                   en_q,
    input logic [ADDR_W-1:PAGE_W] base_q
);
    // R3
    base_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel == 2'd1 && !en_q) |=> $stable(base_q));

    // R3
    base_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == 2'd1 && !en_q) |-> reg_rdata == '0);

    // R4
    page_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == 2'd1 || reg_sel == 2'd2) |-> reg_rdata[PAGE_W-1:0] == '0);

    // R2
    attr_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == 2'd0) |-> reg_rdata[PAGE_W-1:1] == '0);

    // R7
    sel_spare_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == 2'd3) |-> reg_rdata == '0);

    // R5
    hit_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_hit |-> (en_q && base_q != '0));

    // R6
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_hit |-> local_addr == '0);
endmodule

bind inb_xlate_win inb_xlate_win_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_sel    (reg_sel),
    .reg_rdata  (reg_rdata),
    .win_hit    (win_hit),
    .local_addr (local_addr),
    .en_q       (en_q),
    .base_q     (base_q)
);

// File: tb/sim_inb_xlate_win.sv
// Self-checking bench for the inbound translation window.
module sim_inb_xlate_win;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] pci_addr = '0;
    logic        win_hit;
    logic [31:0] local_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    inb_xlate_win u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_sel    (reg_sel),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .pci_addr   (pci_addr),
        .win_hit    (win_hit),
        .local_addr (local_addr)
    );

    // Vectors {pci_addr, hit, local_addr}; window 16 MB, base 4300_0000h, local 1200_0000h.
    localparam logic [64:0] VEC [8] = '{
        {32'h4300_0000, 1'b1, 32'h1200_0000},
        {32'h43AB_CDEF, 1'b1, 32'h12AB_CDEF},
        {32'h43FF_FFFF, 1'b1, 32'h12FF_FFFF},
        {32'h4400_0000, 1'b0, 32'h0000_0000},
        {32'h42FF_FFFF, 1'b0, 32'h0000_0000},
        {32'h0000_0000, 1'b0, 32'h0000_0000},
        {32'hC300_1234, 1'b0, 32'h0000_0000},
        {32'h4380_0FFF, 1'b1, 32'h1280_0FFF}
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] sel, logic [31:0] data);
        @(negedge clk);
        reg_sel   = sel;
        reg_wdata = data;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd(logic [1:0] sel, output logic [31:0] data);
        @(negedge clk);
        reg_sel = sel;
        #1 data = reg_rdata;
    endtask

    task automatic probe(logic [31:0] a, output logic h, output logic [31:0] la);
        @(negedge clk);
        pci_addr = a;
        #1;
        h  = win_hit;
        la = local_addr;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #2ms;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] la;
        logic        h;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd2, d); chk("R1 local after reset", d, 32'h0);
        rd(2'd0, d); chk("R1 mask after reset", d & 32'hFFFF_FFFE, 32'h0);
        wr(2'd0, 32'h0000_0001);
        rd(2'd1, d); chk("R1 base after reset", d, 32'h0);

        // R2 attribute layout: reserved bits read zero
        wr(2'd0, 32'hFF00_0FFF);
        rd(2'd0, d); chk("R2 attr readback", d, 32'hFF00_0001);

        // R4 low bits of base and local are not stored
        wr(2'd1, 32'h4300_0ABC);
        rd(2'd1, d); chk("R4 base low bits", d, 32'h4300_0000);
        wr(2'd2, 32'h1200_0FFF);
        rd(2'd2, d); chk("R4 local low bits", d, 32'h1200_0000);

        // R5 R6 table walk
        for (int i = 0; i < 8; i++) begin
            probe(VEC[i][64:33], h, la);
            chk($sformatf("R5 hit vec%0d", i), {31'd0, h}, {31'd0, VEC[i][32]});
            chk($sformatf("R6 xlate vec%0d", i), la, VEC[i][31:0]);
        end

        // R7 spare select reads zero and writes touch nothing
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd3, d); chk("R7 spare read", d, 32'h0);
        rd(2'd0, d); chk("R7 attr untouched", d, 32'hFF00_0001);
        rd(2'd1, d); chk("R7 base untouched", d, 32'h4300_0000);
        rd(2'd2, d); chk("R7 local untouched", d, 32'h1200_0000);

        // R5 4 KB minimum window: only one page hits
        wr(2'd0, 32'hFFFF_F001);
        probe(32'h4300_0FFF, h, la);
        chk("R5 4K page hit", {31'd0, h}, 32'd1);
        chk("R6 4K xlate", la, 32'h1200_0FFF);
        probe(32'h4300_1000, h, la);
        chk("R5 4K next page miss", {31'd0, h}, 32'd0);

        // R5 disabled window never hits
        wr(2'd0, 32'hFF00_0000);
        probe(32'h4300_0010, h, la);
        chk("R5 disabled miss", {31'd0, h}, 32'd0);
        chk("R6 disabled zero", la, 32'h0);

        // R3 base hidden and write-protected while disabled
        rd(2'd1, d); chk("R3 base reads zero", d, 32'h0);
        wr(2'd1, 32'h7700_0000);
        wr(2'd0, 32'hFF00_0001);
        rd(2'd1, d); chk("R3 base write ignored", d, 32'h4300_0000);

        // R8 shutdown sequence
        wr(2'd1, 32'h0000_0000);
        wr(2'd0, 32'hFF00_0000);
        probe(32'h4300_0000, h, la);
        chk("R8 no hit after shutdown", {31'd0, h}, 32'd0);
        wr(2'd0, 32'hFF00_0001);
        rd(2'd1, d); chk("R8 base stays zero", d, 32'h0);
        probe(32'h0000_0100, h, la);
        chk("R8 zero base no hit", {31'd0, h}, 32'd0);

        // R1 reset clears programmed registers again
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(2'd2, d); chk("R1 local cleared", d, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule